// File: doc/BRIEF.md
# Serial Register Slave with Frame Validation

This block is the slave end of a four-wire SPI link that reads and writes a bank of 8-bit registers. Each transfer is a 16-bit frame, most significant bit first. The first master byte carries a write flag, a 5-bit register address, a parity bit and one ignored bit. The second master byte carries write data.

While the command byte shifts in, the slave returns a status byte. During the second byte it returns the contents of the addressed register.

The serial clock, select and data pins are brought into the system clock domain through two-flop synchronizers. Edges are found by comparing registered samples, so the system clock must run at least four times faster than the serial clock. A write takes effect only when select rises at the end of a frame with exactly sixteen sampling edges and correct parity. Frames that fail either check are dropped and flagged in the status byte of the next frame.

Top module: `spi_reg_slave`

## Requirements
- R1: A falling edge on `cs_ni` starts a new frame. It clears the bit counters, loads the status byte for output and turns on the MISO driver (`miso_en_o` = 1) once the synchronized select is low.
- R2: While `cs_ni` is high, `miso_en_o` is 0 (MISO high impedance). The driver is released in the same cycle that `cs_ni` goes high.
- R3: MOSI is sampled on falling edges of `sck_i`. `miso_o` changes only on rising edges of `sck_i`. The first valid bit (the MSB) appears after the first rising edge following the start of the frame.
- R4: Master bits arrive in this order: write flag, address bits 4 down to 0, parity bit, ignored bit, then data bits 7 down to 0. The ignored bit has no effect.
- R5: A frame is valid only if exactly 16 falling edges of `sck_i` occur while `cs_ni` is low. Any other count, including zero, commits nothing and sets the length-error flag.
- R6: A valid write frame with good parity stores its data byte in the addressed register when `cs_ni` rises.
- R7: The addressed register is captured when the parity bit (the 7th sample) is taken. It is shifted out MSB first during bits 9 to 16 of the same frame, and this happens for read and write frames alike.
- R8: Parity is odd: the write flag, the five address bits and the parity bit together hold an odd number of ones. A 16-edge frame with bad parity commits nothing and sets the parity-error flag.
- R9: A write flag of 1 selects a write and 0 selects a read. A read frame never changes any register, whatever its second byte holds.
- R10: The status byte is {length error, parity error, previous frame committed a write, 5'b10110}, sent MSB first during bits 1 to 8.
- R11: The three status flags are cleared at the start of the frame that reports them, so each is reported once.
- R12: After reset all 32 registers read 0, all flags are 0 and MISO is high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from master |
| cs_ni | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| miso_en_o | output | 1 | MISO driver enable (0 = high impedance) |

## Verification
The bench runs frames of 15 and 17 edges, a frame with no clock edges and frames with flipped parity. A design that counted edges loosely, or checked parity against the wrong polarity, would commit these writes and leave the following status byte without its error flag.

Read frames carry random second bytes. A design that ignored the write flag would overwrite the register, and the next readback exposes it.

Each flag is checked in the status of the frame after the error and again in the frame after that, which catches flags that never clear.

The ID bits and every read byte are compared bit by bit at each rising edge. This exposes an off-by-one in the capture point or in the byte boundary, and an output that moves on the wrong clock edge. The bench also checks the driver enable just after select rises, which catches a late release.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned DATA_W     = 8;
  localparam logic [4:0]  STATUS_ID  = 5'b10110;

  typedef struct packed {
    logic       len_err;
    logic       par_err;
    logic       wr_done;
    logic [4:0] id;
  } status_t;
endpackage

// File: rtl/spi_reg_sync.sv
module spi_reg_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/spi_reg_regfile.sv
module spi_reg_regfile #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[i] <= '0;
      end else if (wr_en_i && wr_addr_i == ADDR_W'(i)) begin
        mem_q[i] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/spi_reg_engine.sv
module spi_reg_engine
  import spi_reg_pkg::*;
#(
  parameter int unsigned FRAME_BITS = spi_reg_pkg::FRAME_BITS,
  parameter int unsigned ADDR_W     = spi_reg_pkg::ADDR_W,
  parameter int unsigned DATA_W     = spi_reg_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_s_i,
  input  logic              cs_s_i,
  input  logic              mosi_s_i,
  output logic              active_o,
  output logic              miso_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int unsigned CNT_MAX = FRAME_BITS + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam int unsigned PAR_IDX = ADDR_W + 1;   // samples taken before parity bit
  localparam int unsigned DC_IDX  = ADDR_W + 2;   // samples taken before ignored bit
  localparam int unsigned RX_W    = FRAME_BITS - 1;
  localparam int unsigned RW_POS  = RX_W - 1;
  localparam int unsigned PAR_POS = DATA_W;

  logic cs_d_q, sck_d_q, active_q;
  logic cs_fall, cs_rise, sck_fall, sck_rise;
  logic [CNT_W-1:0]  bit_cnt_q, rise_cnt_q;
  logic [RX_W-1:0]   rx_q;
  logic [DATA_W-1:0] tx_q, rd_hold_q;
  logic              miso_q;
  logic              len_err_q, par_err_q, wr_done_q;
  logic              frame_len_ok, par_ok, commit;
  status_t           status;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d_q  <= 1'b1;
      sck_d_q <= 1'b0;
    end else begin
      cs_d_q  <= cs_s_i;
      sck_d_q <= sck_s_i;
    end
  end

  assign cs_fall  = cs_d_q & ~cs_s_i;
  assign cs_rise  = ~cs_d_q & cs_s_i;
  assign sck_fall = active_q & ~cs_s_i & sck_d_q & ~sck_s_i;
  assign sck_rise = active_q & ~cs_s_i & ~sck_d_q & sck_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      active_q <= 1'b0;
    else if (cs_fall) active_q <= 1'b1;
    else if (cs_rise) active_q <= 1'b0;
  end

  // receive side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
      rd_hold_q <= '0;
    end else if (cs_fall) begin
      bit_cnt_q <= '0;
    end else if (sck_fall) begin
      if (bit_cnt_q != CNT_W'(CNT_MAX)) bit_cnt_q <= bit_cnt_q + 1'b1;
      if (bit_cnt_q != CNT_W'(DC_IDX))  rx_q <= {rx_q[RX_W-2:0], mosi_s_i};
      if (bit_cnt_q == CNT_W'(PAR_IDX)) rd_hold_q <= rd_data_i;
    end
  end

  assign rd_addr_o = rx_q[ADDR_W-1:0];

  // transmit side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_cnt_q <= '0;
      tx_q       <= '0;
      miso_q     <= 1'b0;
    end else if (cs_fall) begin
      rise_cnt_q <= '0;
      tx_q       <= status;
      miso_q     <= 1'b0;
    end else if (sck_rise) begin
      if (rise_cnt_q != CNT_W'(CNT_MAX)) rise_cnt_q <= rise_cnt_q + 1'b1;
      if (rise_cnt_q == CNT_W'(DATA_W)) begin
        miso_q <= rd_hold_q[DATA_W-1];
        tx_q   <= {rd_hold_q[DATA_W-2:0], 1'b0};
      end else begin
        miso_q <= tx_q[DATA_W-1];
        tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign frame_len_ok = (bit_cnt_q == CNT_W'(FRAME_BITS));
  assign par_ok       = ^rx_q[RW_POS:PAR_POS];
  assign commit       = cs_rise & active_q & frame_len_ok & par_ok & rx_q[RW_POS];

  always_comb begin
    status.len_err = len_err_q;
    status.par_err = par_err_q;
    status.wr_done = wr_done_q;
    status.id      = STATUS_ID;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_err_q <= 1'b0;
      par_err_q <= 1'b0;
      wr_done_q <= 1'b0;
    end else if (cs_fall) begin
      len_err_q <= 1'b0;
      par_err_q <= 1'b0;
      wr_done_q <= 1'b0;
    end else if (cs_rise && active_q) begin
      if (!frame_len_ok)  len_err_q <= 1'b1;
      else if (!par_ok)   par_err_q <= 1'b1;
      else if (rx_q[RW_POS]) wr_done_q <= 1'b1;
    end
  end

  assign wr_en_o   = commit;
  assign wr_addr_o = rx_q[RW_POS-1 -: ADDR_W];
  assign wr_data_o = rx_q[DATA_W-1:0];
  assign active_o  = active_q;
  assign miso_o    = miso_q;

  p_start_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> (active_q && bit_cnt_q == '0 && rise_cnt_q == '0));
  p_idle_after_deselect_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise |=> !active_q);
  p_miso_on_rise_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_rise && !cs_fall) |=> $stable(miso_q));
  p_count_saturates_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= CNT_W'(CNT_MAX));
  p_write_needs_parity_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (^{wr_addr_o, rx_q[RW_POS], rx_q[PAR_POS]}));
  p_write_needs_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> rx_q[RW_POS]);
  p_flags_once_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> (!len_err_q && !par_err_q && !wr_done_q));
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int unsigned FRAME_BITS = spi_reg_pkg::FRAME_BITS,
  parameter int unsigned ADDR_W     = spi_reg_pkg::ADDR_W,
  parameter int unsigned DATA_W     = spi_reg_pkg::DATA_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic miso_o,
  output logic miso_en_o
);
  logic sck_s, cs_s, mosi_s, active;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  spi_reg_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, cs_ni, mosi_i}),
    .q_o   ({sck_s, cs_s, mosi_s})
  );

  spi_reg_engine #(
    .FRAME_BITS(FRAME_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_engine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sck_s_i  (sck_s),
    .cs_s_i   (cs_s),
    .mosi_s_i (mosi_s),
    .active_o (active),
    .miso_o   (miso_o),
    .rd_addr_o(rd_addr),
    .rd_data_i(rd_data),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  spi_reg_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );

  // release at once on deselect, enable after the synchronized start
  assign miso_en_o = active & ~cs_ni;

  p_no_drive_deselected_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni)) |-> !miso_en_o);
endmodule

// File: tb/spi_reg_slave_tb.sv
`timescale 1ns/1ps
module spi_reg_slave_tb;
  localparam time HALF = 40ns;
  localparam logic [4:0] ID = 5'b10110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_en;

  int checks = 0, errors = 0;
  logic [7:0] model [32];
  logic m_len = 0, m_par = 0, m_wr = 0;

  always #2.5ns clk = ~clk;

  spi_reg_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n),
    .mosi_i(mosi), .miso_o(miso), .miso_en_o(miso_en)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic odd_par(input logic rw, input logic [4:0] a);
    return ~(^{rw, a});
  endfunction

  function automatic logic [15:0] mk_frame(input logic rw, input logic [4:0] a,
                                           input logic bad, input logic dc, input logic [7:0] d);
    return {rw, a, odd_par(rw, a) ^ bad, dc, d};
  endfunction

  function automatic logic [7:0] exp_status();
    return {m_len, m_par, m_wr, ID};
  endfunction

  // one frame of nbits falling edges; checks status, read byte and model update
  task automatic xfer(input int nbits, input logic [15:0] fr, input string tag);
    logic [15:0] got = '0;
    logic [7:0]  st  = exp_status();
    logic [7:0]  rdv = model[fr[14:10]];
    logic        par_good = ^fr[15:9];
    cs_n = 1'b0;
    m_len = 0; m_par = 0; m_wr = 0;
    #(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? fr[15-i] : 1'b0;
      sck = 1'b1;
      #(HALF);
      if (i < 16) got[15-i] = miso;
      if (i == 2) check({tag, " R1 driver on"}, 16'(miso_en), 16'd1);
      sck = 1'b0;
      #(HALF);
    end
    cs_n = 1'b1;
    #1ns;
    check({tag, " R2 release"}, 16'(miso_en), 16'd0);
    if (nbits >= 8)  check({tag, " R10 status"}, 16'(got[15:8]), 16'(st));
    if (nbits >= 16) check({tag, " R7 read data"}, 16'(got[7:0]), 16'(rdv));
    if (nbits != 16) m_len = 1;
    else if (!par_good) m_par = 1;
    else if (fr[15]) begin
      m_wr = 1;
      model[fr[14:10]] = fr[7:0];
    end
    #(10 * 5ns);
  endtask

  task automatic read_chk(input logic [4:0] a, input string tag);
    xfer(16, mk_frame(1'b0, a, 1'b0, 1'b0, 8'h00), tag);
  endtask

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    #1ns;
    #(20ns);
    check("R12 hiz in reset", 16'(miso_en), 16'd0);
    rst_n = 1'b1;
    #(20ns);
    check("R12 hiz after reset", 16'(miso_en), 16'd0);

    read_chk(5'd0,  "R12 reg0 zero");
    read_chk(5'd31, "R12 reg31 zero");
    xfer(16, mk_frame(1'b1, 5'd31, 1'b0, 1'b1, 8'hC3), "R6 write top");
    xfer(16, mk_frame(1'b1, 5'd0,  1'b0, 1'b0, 8'h5A), "R6 write low");
    read_chk(5'd31, "R6 readback top");
    read_chk(5'd0,  "R4 readback low");
    xfer(16, mk_frame(1'b1, 5'd3, 1'b0, 1'b0, 8'hA5), "R6 write 3");
    xfer(16, mk_frame(1'b0, 5'd3, 1'b0, 1'b1, 8'hFF), "R9 read w data");
    read_chk(5'd3, "R9 unchanged");
    xfer(16, mk_frame(1'b1, 5'd3, 1'b1, 1'b0, 8'h11), "R8 bad parity");
    read_chk(5'd3, "R8 flag and no write");
    read_chk(5'd3, "R11 flag cleared");
    xfer(15, mk_frame(1'b1, 5'd7, 1'b0, 1'b0, 8'h77), "R5 short");
    read_chk(5'd7, "R5 short no write");
    xfer(17, mk_frame(1'b1, 5'd8, 1'b0, 1'b0, 8'h88), "R5 long");
    read_chk(5'd8, "R5 long no write");
    xfer(0, 16'h0, "R5 no clock");
    read_chk(5'd8, "R11 len flag once");
    read_chk(5'd8, "R11 len flag gone");

    for (int n = 0; n < 60; n++) begin
      int nb = 16;
      logic [15:0] fr;
      if ($urandom_range(9) == 0) nb = ($urandom_range(1) != 0) ? int'($urandom_range(15, 8)) : 17;
      fr = mk_frame(1'($urandom_range(1)), 5'($urandom_range(31)),
                    ($urandom_range(9) == 0), 1'($urandom_range(1)), 8'($urandom));
      xfer(nb, fr, "R3 random");
    end
    for (int a = 0; a < 32; a += 5) read_chk(5'(a), "R9 final sweep");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule